// File: doc/BRIEF.md
# Sequential Signed Divider with Condition Flags

This block divides a 32-bit two's complement dividend by a 16-bit two's complement divisor over several clock cycles. It returns a 16-bit quotient, a 16-bit remainder and four condition flags: negative, zero, overflow and carry. The quotient is truncated toward zero, and the remainder takes the sign of the dividend. The block is meant to sit behind a processor's execute stage as the unit that carries out a long-divide instruction.

A caller presents both operands together with a one-cycle `start` pulse while `busy` is low. Internally the block converts the operands to magnitudes. It first doubles the divisor magnitude until it lines up with the dividend, then runs one restoring shift-and-subtract step per cycle. If the running remainder reaches zero before the last step, the loop stops and the quotient is padded with zero bits for the steps that were skipped. Finally the signs are applied to the results. A zero divisor or a zero dividend skips the loop and finishes in the cycle after `start`.

Top module: `sdiv_flags`

## Requirements
- R1: For a nonzero dividend and nonzero divisor whose true quotient magnitude is below 32768, `quotient` equals the dividend divided by the divisor, truncated toward zero, as a 16-bit two's complement value.
- R2: In the case of R1, `remainder` has the magnitude |dividend| mod |divisor| and the sign of the dividend. For example, -4/3 gives quotient -1 and remainder -1, and 4/-3 gives quotient -1 and remainder 1.
- R3: A zero divisor gives `flags` = 4'b0011 (overflow and carry set, negative and zero clear). `done` rises in the cycle after `start`.
- R4: A zero dividend with a nonzero divisor gives `quotient` = 0, `remainder` = 0 and `flags` = 4'b0111 (zero, overflow and carry set, negative clear). `done` rises in the cycle after `start`.
- R5: For nonzero operands, the overflow flag `flags[1]` is set exactly when |dividend| / |divisor| is at least 32768. This includes a true quotient of -32768. The carry flag `flags[0]` is clear. Quotient, remainder, negative and zero are unspecified while overflow is set.
- R6: When overflow is clear, the negative flag `flags[3]` equals bit 15 of `quotient`, and the zero flag `flags[2]` is set exactly when `quotient` is zero.
- R7: The flag bit positions are: bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry. On the looping path, `flags` reads 4'b0000 from the cycle after `start` until `done`.
- R8: `start` is accepted only while `busy` is low, and a `start` while busy has no effect. `busy` is high from the cycle after an accepted `start` through the cycle in which `done` is high. `done` is a one-cycle pulse, and `busy` is low in the cycle after it.
- R9: `quotient`, `remainder` and `flags` hold their values after `done` until the next accepted `start`.
- R10: An exact division whose remainder reaches zero before the final step still returns the full-width quotient, with the skipped low bits zero, and a zero remainder. An example is 0x6000 / 3 = 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; operands are sampled with it |
| dividend | input | 32 | Two's complement dividend |
| divisor | input | 16 | Two's complement divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | 16 | Signed quotient |
| remainder | output | 16 | Signed remainder, sign of the dividend |
| flags | output | 4 | {negative, zero, overflow, carry} |

## Verification
The assertions assume that `start` is only meaningful as a single-cycle pulse and that the operands are steady on the edge where it is accepted. They also assume reset is applied before the first request. The stimulus always raises `start` for exactly one cycle, away from the clock edge, and changes the operands only together with it. The one exception is a deliberate extra pulse during a busy period, which checks that such a pulse is ignored. Results are compared with an arithmetic model. Quotient, remainder and the negative and zero flags are masked out wherever overflow makes them unspecified.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALIGN = 3'd1,
    ST_STEP  = 3'd2,
    ST_PAD   = 3'd3,
    ST_FIN   = 3'd4
  } loop_st_t;
endpackage

// File: rtl/sdiv_mag.sv
module sdiv_mag #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] mag,
  output logic         neg
);
  // Magnitude is unsigned, so the most negative value maps to 2^(W-1).
  assign neg = val[W-1];
  assign mag = neg ? (~val + 1'b1) : val;
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
  import sdiv_pkg::*;
#(
  parameter int QW = 16,
  localparam int DW = 2 * QW,
  localparam int CW = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] a_mag,
  input  logic [QW-1:0] b_mag,
  output logic [QW-1:0] q_mag,
  output logic [QW-1:0] r_mag,
  output logic          ovf,
  output logic          fin
);
  loop_st_t      st_q;
  logic [DW-1:0] rem_q, dvs_q;
  logic [QW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;

  logic          fits;
  logic [DW-1:0] diff;
  assign fits = (dvs_q <= rem_q);
  assign diff = rem_q - dvs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load) begin
          rem_q <= a_mag;
          dvs_q <= {{(DW-QW){1'b0}}, b_mag};
          quo_q <= '0;
          cnt_q <= '0;
          ovf_q <= 1'b0;
          st_q  <= ST_ALIGN;
        end
        ST_ALIGN: begin
          if ((dvs_q < rem_q) && !dvs_q[DW-1]) begin
            dvs_q <= dvs_q << 1;
            cnt_q <= cnt_q + 1'b1;
          end else begin
            st_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          // Shifting bit QW-2 into the top bit signals a quotient that cannot fit.
          ovf_q <= ovf_q | quo_q[QW-2];
          if (fits) begin
            quo_q <= {quo_q[QW-2:0], 1'b1};
            rem_q <= diff;
          end else begin
            quo_q <= {quo_q[QW-2:0], 1'b0};
          end
          if (fits && (diff == '0)) begin
            st_q <= ST_PAD;
          end else if (cnt_q == '0) begin
            st_q <= ST_FIN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            dvs_q <= dvs_q >> 1;
          end
        end
        ST_PAD: begin
          if (cnt_q == '0) begin
            st_q <= ST_FIN;
          end else begin
            ovf_q <= ovf_q | quo_q[QW-2];
            quo_q <= {quo_q[QW-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign q_mag = quo_q;
  assign r_mag = rem_q[QW-1:0];
  assign ovf   = ovf_q;
  assign fin   = (st_q == ST_FIN);

  // R10: padding after an exact result never touches the remainder
  assert_pad_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAD) |=> $stable(rem_q));
  // R8: completion indication lasts one cycle
  assert_fin_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/sdiv_sign.sv
module sdiv_sign
  import sdiv_pkg::*;
#(
  parameter int QW = 16
) (
  input  logic [QW-1:0] q_mag,
  input  logic [QW-1:0] r_mag,
  input  logic          ovf,
  input  logic          a_neg,
  input  logic          b_neg,
  output logic [QW-1:0] q_s,
  output logic [QW-1:0] r_s,
  output cc_t           cc
);
  always_comb begin
    q_s  = (a_neg ^ b_neg) ? (~q_mag + 1'b1) : q_mag;
    r_s  = a_neg ? (~r_mag + 1'b1) : r_mag;
    cc.n = q_s[QW-1];
    cc.z = (q_s == '0);
    cc.v = ovf;
    cc.c = 1'b0;
  end
endmodule

// File: rtl/sdiv_flags.sv
module sdiv_flags
  import sdiv_pkg::*;
#(
  parameter int QW = 16,
  localparam int DW = 2 * QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [QW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient,
  output logic [QW-1:0] remainder,
  output logic [3:0]    flags
);
  logic [DW-1:0] a_mag;
  logic [QW-1:0] b_mag;
  logic          a_neg, b_neg, an_q, bn_q;
  logic          busy_q, done_q, accept, zero_b, zero_a, load;
  logic [QW-1:0] q_mag, r_mag, q_s, r_s, q_q, r_q;
  logic          ovf, fin;
  cc_t           cc_s, cc_q;

  sdiv_mag #(.W(DW)) u_amag (.val(dividend), .mag(a_mag), .neg(a_neg));
  sdiv_mag #(.W(QW)) u_bmag (.val(divisor),  .mag(b_mag), .neg(b_neg));

  assign accept = start && !busy_q;
  assign zero_b = (divisor == '0);
  assign zero_a = (dividend == '0);
  assign load   = accept && !zero_b && !zero_a;

  sdiv_core #(.QW(QW)) u_core (
    .clk(clk), .rst(rst), .load(load), .a_mag(a_mag), .b_mag(b_mag),
    .q_mag(q_mag), .r_mag(r_mag), .ovf(ovf), .fin(fin)
  );

  sdiv_sign #(.QW(QW)) u_sign (
    .q_mag(q_mag), .r_mag(r_mag), .ovf(ovf), .a_neg(an_q), .b_neg(bn_q),
    .q_s(q_s), .r_s(r_s), .cc(cc_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      q_q    <= '0;
      r_q    <= '0;
      cc_q   <= '0;
      an_q   <= 1'b0;
      bn_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (done_q) busy_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        if (zero_b) begin
          cc_q   <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b1};
          done_q <= 1'b1;
        end else if (zero_a) begin
          cc_q   <= '{n: 1'b0, z: 1'b1, v: 1'b1, c: 1'b1};
          q_q    <= '0;
          r_q    <= '0;
          done_q <= 1'b1;
        end else begin
          cc_q <= '0;
          an_q <= a_neg;
          bn_q <= b_neg;
        end
      end
      if (fin) begin
        q_q    <= q_s;
        r_q    <= r_s;
        cc_q   <= cc_s;
        done_q <= 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign quotient  = q_q;
  assign remainder = r_q;
  assign flags     = cc_q;

  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |-> (flags == 4'b0000));
  // R3: carry only ever appears together with overflow, never with negative
  assert_carry_implies_v_R3: assert property (@(posedge clk) disable iff (rst)
    (done && flags[0]) |-> (flags[1] && !flags[3]));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(flags)));
endmodule

// File: tb/sim_sdiv_flags.sv
module sim_sdiv_flags;
  logic        clk = 1'b0;
  logic        rst, start;
  logic [31:0] dvd;
  logic [15:0] dvs;
  logic        busy, done;
  logic [15:0] quo, rem;
  logic [3:0]  fl;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sdiv_flags u0 (
    .clk(clk), .rst(rst), .start(start), .dividend(dvd), .divisor(dvs),
    .busy(busy), .done(done), .quotient(quo), .remainder(rem), .flags(fl)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Arithmetic model built from the requirements.
  task automatic model(input logic [31:0] a, input logic [15:0] b,
                       output logic [15:0] q, output logic [15:0] r,
                       output logic [3:0] f, output logic [3:0] m,
                       output bit cmp_qr);
    longint av, bv, am, bm, qm, rm, qv, rv;
    q = '0; r = '0;
    av = longint'($signed(a));
    bv = longint'($signed(b));
    if (b == 16'h0) begin
      f = 4'b0011; m = 4'b1111; cmp_qr = 0;
    end else if (a == 32'h0) begin
      f = 4'b0111; m = 4'b1111; cmp_qr = 1;
    end else begin
      am = (av < 0) ? -av : av;
      bm = (bv < 0) ? -bv : bv;
      qm = am / bm;
      rm = am % bm;
      if (qm >= 32768) begin
        f = 4'b0010; m = 4'b0011; cmp_qr = 0;
      end else begin
        qv = ((av < 0) != (bv < 0)) ? -qm : qm;
        rv = (av < 0) ? -rm : rm;
        q = qv[15:0];
        r = rv[15:0];
        f = {q[15], (q == 16'h0), 2'b00};
        m = 4'b1111; cmp_qr = 1;
      end
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [15:0] b,
                        input string req, output int lat);
    logic [15:0] eq, er;
    logic [3:0]  ef, em;
    bit          cq;
    model(a, b, eq, er, ef, em, cq);
    @(negedge clk);
    dvd = a; dvs = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk("R8", "busy after start", {31'b0, busy}, 32'd1);
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      chk(req, "done timeout", 32'd0, 32'd1);
    end else begin
      chk("R8", "busy with done", {31'b0, busy}, 32'd1);
      if (cq) begin
        chk(req, "quotient", {16'b0, quo}, {16'b0, eq});
        chk(req, "remainder", {16'b0, rem}, {16'b0, er});
      end
      chk(req, "flags", {28'b0, fl & em}, {28'b0, ef & em});
    end
    @(negedge clk);
    chk("R8", "done pulse", {31'b0, done}, 32'd0);
    chk("R8", "busy released", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; dvd = '0; dvs = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "reset busy", {31'b0, busy}, 32'd0);
    chk("R8", "reset done", {31'b0, done}, 32'd0);
    chk("R7", "reset flags", {28'b0, fl}, 32'd0);
  endtask

  task automatic t_signs();
    int l;
    run_op(32'd4, 16'd3, "R1", l);
    chk("R2", "4/3 rem", {16'b0, rem}, 32'd1);
    run_op(-32'sd4, -16'sd3, "R2", l);
    chk("R2", "-4/-3 rem", {16'b0, rem}, 32'h0000FFFF);
    run_op(32'd4, -16'sd3, "R1", l);
    chk("R1", "4/-3 quo", {16'b0, quo}, 32'h0000FFFF);
    run_op(-32'sd4, 16'd3, "R2", l);
    chk("R2", "-4/3 rem", {16'b0, rem}, 32'h0000FFFF);
    run_op(-32'sd1, 16'd3, "R6", l);
    chk("R6", "-1/3 zero flag", {28'b0, fl}, 32'h4);
    run_op(32'd100000, -16'sd7, "R6", l);
  endtask

  task automatic t_zero_div();
    int l;
    run_op(32'h12345678, 16'h0000, "R3", l);
    chk("R3", "latency", l, 1);
    chk("R3", "flags exact", {28'b0, fl}, 32'h3);
  endtask

  task automatic t_zero_dvd();
    int l;
    run_op(32'h0, -16'sd5, "R4", l);
    chk("R4", "latency", l, 1);
    chk("R4", "flags exact", {28'b0, fl}, 32'h7);
  endtask

  task automatic t_overflow();
    int l;
    run_op(-32'sd32768, 16'd1, "R5", l);
    chk("R5", "-32768 overflow", {31'b0, fl[1]}, 32'd1);
    run_op(32'd32767, 16'd1, "R5", l);
    chk("R5", "32767 no overflow", {31'b0, fl[1]}, 32'd0);
    run_op(32'h7FFFFFFF, 16'h7FFF, "R5", l);
    run_op(32'h80000000, 16'h8000, "R5", l);
    run_op(32'h80000000, 16'hFFFF, "R5", l);
    run_op(32'h7FFFFFFF, 16'h8000, "R5", l);
    run_op(32'h3FFF8000, 16'h8000, "R5", l);
    chk("R5", "-32767*-32768", {16'b0, quo}, 32'h00008001);
  endtask

  task automatic t_exact();
    int l;
    run_op(32'h00006000, 16'd3, "R10", l);
    chk("R10", "padded quotient", {16'b0, quo}, 32'h2000);
    run_op(32'hFFFF8000, 16'd256, "R10", l);
    run_op(32'h00010000, 16'd2, "R10", l);
  endtask

  task automatic t_busy_ignore();
    int l;
    @(negedge clk);
    dvd = 32'd1000; dvs = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    dvd = 32'h0; dvs = 16'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    l = 0;
    while (!done && l < 300) begin
      @(negedge clk);
      l++;
    end
    chk("R8", "ignored start quotient", {16'b0, quo}, 32'd142);
    chk("R8", "ignored start remainder", {16'b0, rem}, 32'd6);
    chk("R8", "ignored start flags", {28'b0, fl}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_hold();
    int l;
    run_op(-32'sd12345, 16'd100, "R9", l);
    repeat (5) @(negedge clk);
    chk("R9", "held quotient", {16'b0, quo}, 32'h0000FF85);
    chk("R9", "held remainder", {16'b0, rem}, 32'h0000FFD3);
    chk("R9", "held flags", {28'b0, fl}, 32'h8);
  endtask

  task automatic t_sweep();
    int l;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      logic [15:0] b;
      a = $urandom;
      b = $urandom;
      a = $signed(a) >>> (i % 24);
      run_op(a, b, "R1", l);
    end
  endtask

  initial begin
    t_reset();
    t_signs();
    t_zero_div();
    t_zero_dvd();
    t_overflow();
    t_exact();
    t_busy_ignore();
    t_hold();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule